// File: doc/BRIEF.md
# Delayed-Branch Pipeline Sequencer

This block owns the program counter of a two-stage fetch/execute pipeline. Each cycle one instruction sits in execute while the next one is fetched. Decode reports what the executing instruction is: its branch kind, its condition code, whether it uses the delayed form, and its target address. The ALU supplies the zero, negative, overflow and carry flags. From these inputs the sequencer picks the next fetch address. It discards the prefetched instruction when a plain branch is taken, and it gives the stack logic the return address for calls.

A delayed branch always lets the prefetched instruction, called the slot, run. This holds whether or not the branch is taken, so a taken branch costs one fetch cycle instead of two. From the delayed branch until its slot has run, the sequencer holds interrupts off. It flags any forbidden instruction that decode reports inside a slot. It also supplies the value that a PC-reading load gets, which inside a slot is the address after the slot. Software can use that value as a cheap return address for leaf routines.

The control is a three-state machine. FILL is an execute cycle that holds no valid instruction (after reset or after a squash). RUN is a normal execute cycle. SLOT is the cycle in which a delay-slot instruction executes. The transitions are: FILL→RUN always; RUN→SLOT on any delayed branch; RUN→FILL on a taken non-delayed branch; RUN→RUN otherwise; SLOT→RUN always. A stall holds the current state.

Top module: `dbr_sequencer`

## Requirements
- R1: A synchronous reset sets `fetch_addr` to the reset vector and enters FILL. In the first execute cycle after reset, the decode inputs have no effect: there is no squash, no push and no redirect.
- R2: In each unstalled cycle with no redirect, `fetch_addr` rises by 2 at the next clock.
- R3: The condition codes are 0 signed greater (Z=0 and N=V), 1 signed greater-or-equal (N=V), 2 signed less (N≠V), 3 signed less-or-equal (Z=1 or N≠V), 4 unsigned greater (C=0 and Z=0), 5 unsigned greater-or-equal (C=0), 6 unsigned less (C=1), 7 unsigned less-or-equal (C=1 or Z=1), 8 equal (Z=1) and 9 not-equal (Z=0). Codes 10 to 15 are never taken. The flag input is packed as {Z,N,V,C}.
- R4: Branch kinds are coded 1 conditional, 2 jump, 3 call and 4 return. A taken branch with `br_delayed`=0, executing in RUN, raises `squash` in that cycle and makes `fetch_addr` equal the target at the next clock. The execute cycle that follows is FILL.
- R5: A conditional branch with `br_delayed`=0 that is not taken raises no squash, and fetch continues in sequence.
- R6: A branch with `br_delayed`=1 never raises `squash`, and its next execute cycle is SLOT. The fetch after it is the target if the branch is taken and the sequential address if it is not.
- R7: A call executing in RUN raises `push_en`. `push_addr` is the call's address plus 2 in the plain form and plus 4 in the delayed form.
- R8: `irq_block` is high in the cycle of a delayed branch executing in RUN and throughout SLOT, and it is low otherwise.
- R9: `slot_fault` equals `slot_forbidden` while in SLOT, and it is 0 in every other state.
- R10: Branch inputs presented during SLOT or FILL cause no redirect, no squash and no push.
- R11: `pc_read` is the address of the executing instruction plus 2, so inside a slot it is the address after the slot.
- R12: While `stall` is high, `fetch_addr`, `pc_read` and the state hold, and `squash` and `push_en` stay low.
- R13: Branch kinds 0 and 5 to 7 act as no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze the pipeline this cycle |
| br_kind | input | 3 | Branch kind of the executing instruction |
| br_cc | input | 4 | Condition code for conditional branches |
| br_delayed | input | 1 | Branch uses the delayed form |
| br_target | input | PCW | Branch, call or return target |
| slot_forbidden | input | 1 | Executing instruction may not sit in a slot |
| flags | input | 4 | ALU flags {Z,N,V,C} |
| fetch_addr | output | PCW | Address being fetched |
| squash | output | 1 | Discard the prefetched instruction |
| push_en | output | 1 | Push a return address |
| push_addr | output | PCW | Return address to push |
| irq_block | output | 1 | Hold off interrupt acceptance |
| slot_fault | output | 1 | Forbidden instruction in a delay slot |
| pc_read | output | PCW | Value for a PC-reading load |

## Verification
The bench sweeps all sixteen condition codes across flag patterns that separate signed from unsigned ordering. A mistake there would take or skip branches on the wrong comparisons. It checks that a not-taken delayed branch still runs its slot. A design that tied the slot to branch outcome would squash it. The bench also checks the delayed call's return address: an off-by-one would re-run the slot after the return. It drives branch and forbidden codes into the slot and into the fill cycle, where a careless design would redirect a second time. Stalls inside a slot are covered too, where a design that let the mask or state move would open an interrupt window or lose the pending slot.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_RUN  = 2'd1,
        ST_SLOT = 2'd2
    } seq_state_t;

    localparam logic [2:0] KIND_COND = 3'd1;
    localparam logic [2:0] KIND_JUMP = 3'd2;
    localparam logic [2:0] KIND_CALL = 3'd3;
    localparam logic [2:0] KIND_RET  = 3'd4;

    localparam logic [3:0] CC_SGT = 4'd0;
    localparam logic [3:0] CC_SGE = 4'd1;
    localparam logic [3:0] CC_SLT = 4'd2;
    localparam logic [3:0] CC_SLE = 4'd3;
    localparam logic [3:0] CC_UGT = 4'd4;
    localparam logic [3:0] CC_UGE = 4'd5;
    localparam logic [3:0] CC_ULT = 4'd6;
    localparam logic [3:0] CC_ULE = 4'd7;
    localparam logic [3:0] CC_EQ  = 4'd8;
    localparam logic [3:0] CC_NE  = 4'd9;

endpackage

// File: rtl/dbr_cond_unit.sv
module dbr_cond_unit
    import dbr_pkg::*;
(
    input  logic [3:0] cc,
    input  logic [3:0] flags,
    output logic       hit
);
    logic fz, fn, fv, fc, below_s;

    assign fz = flags[3];
    assign fn = flags[2];
    assign fv = flags[1];
    assign fc = flags[0];
    assign below_s = fn ^ fv;

    always_comb begin
        case (cc)
            CC_SGT:  hit = !fz && !below_s;
            CC_SGE:  hit = !below_s;
            CC_SLT:  hit = below_s;
            CC_SLE:  hit = fz || below_s;
            CC_UGT:  hit = !fc && !fz;
            CC_UGE:  hit = !fc;
            CC_ULT:  hit = fc;
            CC_ULE:  hit = fc || fz;
            CC_EQ:   hit = fz;
            CC_NE:   hit = !fz;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbr_pc_unit.sv
module dbr_pc_unit #(
    parameter int          PCW       = 24,
    parameter logic [PCW-1:0] RESET_VEC = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic           redirect,
    input  logic [PCW-1:0] target,
    output logic [PCW-1:0] fetch_pc,
    output logic [PCW-1:0] exec_pc
);
    localparam logic [PCW-1:0] STEP = PCW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_pc <= RESET_VEC;
            exec_pc  <= RESET_VEC;
        end else if (advance) begin
            exec_pc  <= fetch_pc;
            fetch_pc <= redirect ? target : fetch_pc + STEP;
        end
    end
endmodule

// File: rtl/dbr_sequencer.sv
module dbr_sequencer
    import dbr_pkg::*;
#(
    parameter int             PCW       = 24,
    parameter logic [PCW-1:0] RESET_VEC = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stall,
    input  logic [2:0]     br_kind,
    input  logic [3:0]     br_cc,
    input  logic           br_delayed,
    input  logic [PCW-1:0] br_target,
    input  logic           slot_forbidden,
    input  logic [3:0]     flags,
    output logic [PCW-1:0] fetch_addr,
    output logic           squash,
    output logic           push_en,
    output logic [PCW-1:0] push_addr,
    output logic           irq_block,
    output logic           slot_fault,
    output logic [PCW-1:0] pc_read
);
    localparam logic [PCW-1:0] ONE_INSN = PCW'(2);
    localparam logic [PCW-1:0] TWO_INSN = PCW'(4);

    seq_state_t     state, state_nx;
    logic           cond_hit, kind_valid, taken, in_run, redirect;
    logic [PCW-1:0] exec_pc;

    dbr_cond_unit u_cond (
        .cc    (br_cc),
        .flags (flags),
        .hit   (cond_hit)
    );

    assign kind_valid = (br_kind >= KIND_COND) && (br_kind <= KIND_RET);
    assign taken      = ((br_kind == KIND_COND) && cond_hit)
                      || (br_kind == KIND_JUMP)
                      || (br_kind == KIND_CALL)
                      || (br_kind == KIND_RET);
    assign in_run     = (state == ST_RUN);
    assign redirect   = in_run && taken;

    dbr_pc_unit #(.PCW(PCW), .RESET_VEC(RESET_VEC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .advance  (!stall),
        .redirect (redirect),
        .target   (br_target),
        .fetch_pc (fetch_addr),
        .exec_pc  (exec_pc)
    );

    always_ff @(posedge clk) begin
        if (rst)         state <= ST_FILL;
        else if (!stall) state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL: state_nx = ST_RUN;
            ST_RUN: begin
                if (kind_valid && br_delayed) state_nx = ST_SLOT;
                else if (taken)               state_nx = ST_FILL;
                else                          state_nx = ST_RUN;
            end
            ST_SLOT: state_nx = ST_RUN;
            default: state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        squash     = 1'b0;
        push_en    = 1'b0;
        irq_block  = 1'b0;
        slot_fault = 1'b0;
        push_addr  = exec_pc + (br_delayed ? TWO_INSN : ONE_INSN);
        pc_read    = exec_pc + ONE_INSN;
        unique case (state)
            ST_FILL: ;
            ST_RUN: begin
                squash    = !stall && taken && !br_delayed;
                push_en   = !stall && (br_kind == KIND_CALL);
                irq_block = kind_valid && br_delayed;
            end
            ST_SLOT: begin
                irq_block  = 1'b1;
                slot_fault = slot_forbidden;
            end
            default: ;
        endcase
    end
endmodule

module dbr_sequencer_chk
    import dbr_pkg::*;
#(
    parameter int PCW = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           stall,
    input logic           br_delayed,
    input logic [PCW-1:0] br_target,
    input logic [PCW-1:0] fetch_addr,
    input logic           squash,
    input logic           push_en,
    input logic [PCW-1:0] push_addr,
    input logic           irq_block,
    input logic           slot_fault,
    input logic [PCW-1:0] pc_read,
    input seq_state_t     state
);
    localparam logic [PCW-1:0] ONE_INSN = PCW'(2);

    assert_redirect_R4: assert property (@(posedge clk) disable iff (rst)
        squash |=> fetch_addr == $past(br_target));

    assert_slot_kept_R6: assert property (@(posedge clk) disable iff (rst)
        squash |-> !br_delayed);

    assert_push_after_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (push_en && br_delayed) |-> push_addr == pc_read + ONE_INSN);

    assert_slot_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLOT) |-> irq_block);

    assert_fault_masked_R9: assert property (@(posedge clk) disable iff (rst)
        slot_fault |-> irq_block);

    assert_slot_no_redirect_R10: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_SLOT) && !stall) |=> fetch_addr == $past(fetch_addr) + ONE_INSN);

    assert_freeze_R12: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_addr) && $stable(pc_read)));

    assert_stall_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!squash && !push_en));
endmodule

bind dbr_sequencer dbr_sequencer_chk #(.PCW(PCW)) u_chk (.*);

// File: tb/dbr_sequencer_bench.sv
module dbr_sequencer_bench;
    localparam int PCW = 24;
    localparam logic [PCW-1:0] RV = 24'h000100;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           stall = 1'b0;
    logic [2:0]     br_kind = '0;
    logic [3:0]     br_cc = '0;
    logic           br_delayed = 1'b0;
    logic [PCW-1:0] br_target = '0;
    logic           slot_forbidden = 1'b0;
    logic [3:0]     flags = '0;
    logic [PCW-1:0] fetch_addr, push_addr, pc_read;
    logic           squash, push_en, irq_block, slot_fault;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state: 0 fill, 1 run, 2 slot
    logic [PCW-1:0] mf, mx;
    int             mm;

    always #5 clk = ~clk;

    dbr_sequencer #(.PCW(PCW), .RESET_VEC(RV)) u_dbr_sequencer (
        .clk(clk), .rst(rst), .stall(stall), .br_kind(br_kind), .br_cc(br_cc),
        .br_delayed(br_delayed), .br_target(br_target),
        .slot_forbidden(slot_forbidden), .flags(flags),
        .fetch_addr(fetch_addr), .squash(squash), .push_en(push_en),
        .push_addr(push_addr), .irq_block(irq_block), .slot_fault(slot_fault),
        .pc_read(pc_read)
    );

    function automatic bit cond_ok(int cc, logic [3:0] f);
        bit z = f[3], n = f[2], v = f[1], c = f[0];
        bit lt = (n != v);
        case (cc)
            0: return !z && !lt;
            1: return !lt;
            2: return lt;
            3: return z || lt;
            4: return !c && !z;
            5: return !c;
            6: return c;
            7: return c || z;
            8: return z;
            9: return !z;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(string tag, int k, int cc, bit d, logic [PCW-1:0] t,
                        bit fb, logic [3:0] fl, bit st);
        bit kv, tk, e_sq, e_push, e_irq;
        logic [PCW-1:0] nx;
        br_kind = 3'(k); br_cc = 4'(cc); br_delayed = d; br_target = t;
        slot_forbidden = fb; flags = fl; stall = st;
        #4;
        kv = (k >= 1) && (k <= 4);
        tk = ((k == 1) && cond_ok(cc, fl)) || (k == 2) || (k == 3) || (k == 4);
        e_sq   = !rst && !st && (mm == 1) && kv && tk && !d;
        e_push = !rst && !st && (mm == 1) && (k == 3);
        e_irq  = (mm == 2) || ((mm == 1) && kv && d);
        if (!rst) begin
            chk({tag, "/R2"},  "fetch_addr", 32'(fetch_addr), 32'(mf));
            chk({tag, "/R4"},  "squash",     32'(squash),     32'(e_sq));
            chk({tag, "/R7"},  "push_en",    32'(push_en),    32'(e_push));
            if (e_push)
                chk({tag, "/R7"}, "push_addr", 32'(push_addr), 32'(mx + (d ? 4 : 2)));
            chk({tag, "/R8"},  "irq_block",  32'(irq_block),  32'(e_irq));
            chk({tag, "/R9"},  "slot_fault", 32'(slot_fault), 32'((mm == 2) && fb));
            chk({tag, "/R11"}, "pc_read",    32'(pc_read),    32'(mx + 2));
        end
        @(posedge clk);
        if (rst) begin
            mf = RV; mx = RV; mm = 0;
        end else if (!st) begin
            nx = mf;
            if (mm == 1 && kv && d) begin
                mf = tk ? t : mf + 2; mm = 2;
            end else if (mm == 1 && tk) begin
                mf = t; mm = 0;
            end else begin
                mf = mf + 2; mm = 1;
            end
            mx = nx;
        end
        @(negedge clk);
    endtask

    task automatic nop(string tag);
        step(tag, 0, 0, 0, '0, 0, 4'h0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mf = '0; mx = '0; mm = 0;
        @(negedge clk);
        rst = 1'b1;
        nop("R1");
        nop("R1");
        rst = 1'b0;
        // R1: reset state, then the fill cycle ignores a jump
        chk("R1", "fetch_addr", 32'(fetch_addr), 32'(RV));
        chk("R1", "irq_block", 32'(irq_block), 32'(0));
        step("R1", 2, 0, 0, 24'h00F000, 0, 4'h0, 0);
        chk("R1", "fetch_addr", 32'(fetch_addr), 32'(RV + 2));

        repeat (4) nop("R2");

        // R3 / R5: every condition code against distinguishing flag sets
        for (int cc = 0; cc < 16; cc++) begin
            for (int p = 0; p < 6; p++) begin
                logic [3:0] fl;
                case (p)
                    0: fl = 4'b0000;
                    1: fl = 4'b0100;
                    2: fl = 4'b1000;
                    3: fl = 4'b0001;
                    4: fl = 4'b0110;
                    default: fl = 4'b0010;
                endcase
                step("R3", 1, cc, 0, PCW'(24'h002000 + cc * 64 + p * 8), 0, fl, 0);
                nop("R5");
            end
        end

        // R6: delayed conditional, taken then not taken; delayed jump and return
        step("R6", 1, 8, 1, 24'h003000, 0, 4'b1000, 0);
        nop("R6");
        nop("R6");
        step("R6", 1, 8, 1, 24'h003100, 0, 4'b0000, 0);
        nop("R6");
        chk("R6", "no redirect", 32'(fetch_addr), 32'(mf));
        step("R6", 2, 0, 1, 24'h003200, 0, 4'h0, 0);
        nop("R6");
        step("R6", 4, 0, 1, 24'h003300, 0, 4'h0, 0);
        nop("R6");

        // R7: plain and delayed calls
        step("R7", 3, 0, 0, 24'h004000, 0, 4'h0, 0);
        nop("R7");
        nop("R7");
        step("R7", 3, 0, 1, 24'h004100, 0, 4'h0, 0);
        nop("R11");
        nop("R7");

        // R9 / R10: forbidden branch inside a slot has no control effect
        step("R10", 2, 0, 1, 24'h005000, 0, 4'h0, 0);
        step("R10", 3, 0, 0, 24'h00EEEE, 1, 4'h0, 0);
        step("R9", 0, 0, 0, '0, 1, 4'h0, 0);
        step("R10", 2, 0, 0, 24'h005100, 0, 4'h0, 0);
        step("R10", 2, 0, 0, 24'h00DDDD, 0, 4'h0, 0);
        nop("R10");

        // R12: stalls inside a slot and on a branch in run
        step("R12", 2, 0, 1, 24'h006000, 0, 4'h0, 0);
        repeat (3) step("R12", 3, 0, 0, 24'h00CCCC, 1, 4'h0, 1);
        nop("R12");
        step("R12", 2, 0, 0, 24'h006100, 0, 4'h0, 1);
        step("R12", 2, 0, 0, 24'h006100, 0, 4'h0, 0);
        nop("R12");

        // R13: unused kind codes
        for (int k = 5; k < 8; k++) step("R13", k, 0, 1, 24'h00BBBB, 0, 4'h0, 0);
        nop("R13");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule